// File: doc/BRIEF.md
# Horizontal Compression Resampler

This block shrinks a line of 8-bit video samples horizontally by a programmable ratio anywhere from 1 to 2. A phase accumulator works in units of 1/256 of an input sample. For each output sample it gives the position of the left input neighbour and a fractional phase. A linear interpolator then blends that neighbour with the next input sample. Each input sample produces at most one output sample. When the accumulator moves forward by two whole samples, the next input produces nothing. A valid strobe marks the output cycles that carry a result.

The ratio is 1 + cf/255, where cf is an 8-bit control value. A line-start pulse re-anchors the accumulator. A select input decides which pin supplies that pulse: the write-enable pulse or the horizontal reference pulse. When resampling is switched off, input samples reach the output unchanged after one register stage.

Top module: `dto_resampler`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid` is 0. After `rst`, the accumulator sits at position 0 with no samples held, the same state as a line start with no sample.
- R2: The accumulator step, in 1/256 sample units, is 256 + floor((cf*256 + 127)/255). So cf=0 gives step 256, where every input yields one output equal to the sample before it. cf=255 gives step 512, where every second input yields an output.
- R3: With position P (integer part p, fraction f = P mod 256), an output is produced in the cycle that delivers input sample p+1. It appears on `out_valid`/`out_data` one clock later, and then P increases by the step.
- R4: With a = sample p and b = sample p+1, the output is a + floor(((b − a)·f + 128)/256), clamped to 0..255. This holds for rising and for falling data.
- R5: The integer advance is 1 or 2. When it is 2, one input sample contributes to no output.
- R6: With `line_sel`=0, `we_pulse` starts a line and `href_pulse` is ignored. With `line_sel`=1 the roles are swapped.
- R7: A line start clears the position to 0 and discards the held samples. An input sample that arrives in the same cycle becomes sample 0 of the new line.
- R8: With `dto_on`=0, `out_valid` and `out_data` equal the previous cycle's `in_valid` and `in_data`.
- R9: `out_valid` is never high unless `in_valid` was high in the previous cycle. Cycles where `in_valid` is low do not move the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cf | input | 8 | Compression factor code |
| dto_on | input | 1 | 1 = resample, 0 = pass through |
| line_sel | input | 1 | Line-start source: 0 write-enable, 1 horizontal reference |
| we_pulse | input | 1 | Write-enable line-start pulse |
| href_pulse | input | 1 | Horizontal reference line-start pulse |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 8 | Input sample |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 8 | Output sample |

## Verification
The step is registered one clock after `cf`. The checks therefore assume that `cf` does not change while a line is being processed. The stimulus changes `cf` only during idle cycles, several clocks before the next line-start pulse. `rst` is held high for at least two clocks, so that the range check on the output has a defined previous cycle. The stimulus includes gaps in `in_valid`, line starts that coincide with a sample, pulses on the unselected line-start pin, and mode changes between lines.

// File: rtl/dto_rs_pkg.sv
package dto_rs_pkg;
  // count of input samples still needed before the next neighbour pair is complete
  typedef logic [1:0] need_t;
  localparam need_t NEED_PAIR = 2'd2;
  localparam need_t NEED_ONE  = 2'd1;
endpackage

// File: rtl/dto_step_gen.sv
module dto_step_gen #(
  parameter int CF_W   = 8,
  parameter int FRAC_W = 8,
  parameter int STEP_W = FRAC_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CF_W-1:0]   cf,
  output logic [STEP_W-1:0] step
);
  localparam int ONE    = 1 << FRAC_W;
  localparam int CF_MAX = (1 << CF_W) - 1;
  localparam int NUM_W  = CF_W + FRAC_W + 1;

  logic [NUM_W-1:0]  num;
  logic [NUM_W-1:0]  quo;

  always_comb begin
    num = ({{(FRAC_W+1){1'b0}}, cf} << FRAC_W) + NUM_W'(CF_MAX / 2);
    quo = num / NUM_W'(CF_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) step <= STEP_W'(ONE);
    else     step <= STEP_W'(ONE) + quo[STEP_W-1:0];
  end

  // R2
  step_range_chk: assert property (@(posedge clk) disable iff (rst)
    (step >= STEP_W'(ONE)) && (step <= STEP_W'(2*ONE)));
endmodule

// File: rtl/dto_accum.sv
module dto_accum
  import dto_rs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FRAC_W = 8,
  parameter int STEP_W = FRAC_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [STEP_W-1:0] step,
  output logic              pair_fire,
  output logic [DATA_W-1:0] left_smp,
  output logic [DATA_W-1:0] right_smp,
  output logic [FRAC_W-1:0] phase
);
  localparam int SUM_W = STEP_W + 1;

  logic [FRAC_W-1:0] frac_q;
  need_t             need_q;
  logic [DATA_W-1:0] prev_q;
  logic [SUM_W-1:0]  sum;
  need_t             adv;

  always_comb begin
    sum       = SUM_W'(frac_q) + SUM_W'(step);
    adv       = sum[FRAC_W +: 2];
    pair_fire = in_valid && !line_start && (need_q == NEED_ONE);
    left_smp  = prev_q;
    right_smp = in_data;
    phase     = frac_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frac_q <= '0;
      need_q <= NEED_PAIR;
      prev_q <= '0;
    end else if (line_start) begin
      frac_q <= '0;
      need_q <= in_valid ? NEED_ONE : NEED_PAIR;
      if (in_valid) prev_q <= in_data;
    end else if (in_valid) begin
      prev_q <= in_data;
      if (need_q == NEED_ONE) begin
        frac_q <= sum[FRAC_W-1:0];
        need_q <= adv;
      end else begin
        need_q <= need_q - 2'd1;
      end
    end
  end

  // R5
  adv_range_chk: assert property (@(posedge clk) disable iff (rst)
    pair_fire |=> (need_q == NEED_ONE) || (need_q == NEED_PAIR));
  // R7
  line_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (line_start && !in_valid) |=> (frac_q == '0) && (need_q == NEED_PAIR));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !line_start) |=> $stable(frac_q) && $stable(need_q));
endmodule

// File: rtl/dto_lerp.sv
module dto_lerp #(
  parameter int DATA_W = 8,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bypass,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              fire,
  input  logic [DATA_W-1:0] smp_a,
  input  logic [DATA_W-1:0] smp_b,
  input  logic [FRAC_W-1:0] frac,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int D_W   = DATA_W + 1;
  localparam int P_W   = DATA_W + FRAC_W + 3;
  localparam int MAXV  = (1 << DATA_W) - 1;

  logic signed [D_W-1:0] diff;
  logic signed [P_W-1:0] prod;
  logic signed [P_W-1:0] blend;
  logic [DATA_W-1:0]     clamped;

  always_comb begin
    diff  = $signed({1'b0, smp_b}) - $signed({1'b0, smp_a});
    prod  = P_W'(diff) * $signed({{(P_W-FRAC_W){1'b0}}, frac});
    blend = $signed(P_W'({1'b0, smp_a}))
          + ((prod + P_W'(1 << (FRAC_W - 1))) >>> FRAC_W);
    if (blend < 0)                      clamped = '0;
    else if (blend > P_W'(MAXV))        clamped = DATA_W'(MAXV);
    else                                clamped = blend[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (bypass) begin
      out_valid <= in_valid;
      out_data  <= in_data;
    end else begin
      out_valid <= fire;
      if (fire) out_data <= clamped;
    end
  end

  // R4
  between_nbrs_chk: assert property (@(posedge clk) disable iff (rst)
    $past(fire && !bypass) |->
      out_valid &&
      (out_data >= (($past(smp_a) < $past(smp_b)) ? $past(smp_a) : $past(smp_b))) &&
      (out_data <= (($past(smp_a) < $past(smp_b)) ? $past(smp_b) : $past(smp_a))));
endmodule

// File: rtl/dto_resampler.sv
module dto_resampler #(
  parameter int DATA_W = 8,
  parameter int CF_W   = 8,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CF_W-1:0]   cf,
  input  logic              dto_on,
  input  logic              line_sel,
  input  logic              we_pulse,
  input  logic              href_pulse,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int STEP_W = FRAC_W + 2;

  logic [STEP_W-1:0] step;
  logic              line_start;
  logic              fire;
  logic [DATA_W-1:0] smp_a, smp_b;
  logic [FRAC_W-1:0] frac;

  assign line_start = line_sel ? href_pulse : we_pulse;

  dto_step_gen #(.CF_W(CF_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) u_step (
    .clk(clk), .rst(rst), .cf(cf), .step(step));

  dto_accum #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) u_accum (
    .clk(clk), .rst(rst), .line_start(line_start), .in_valid(in_valid),
    .in_data(in_data), .step(step), .pair_fire(fire), .left_smp(smp_a),
    .right_smp(smp_b), .phase(frac));

  dto_lerp #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_lerp (
    .clk(clk), .rst(rst), .bypass(!dto_on), .in_valid(in_valid),
    .in_data(in_data), .fire(fire), .smp_a(smp_a), .smp_b(smp_b),
    .frac(frac), .out_valid(out_valid), .out_data(out_data));

  // R8
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!dto_on && in_valid) |=> out_valid && (out_data == $past(in_data)));
  // R9
  no_idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

// File: tb/dto_resampler_tb_top.sv
module dto_resampler_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cf = '0;
  logic       dto_on = 1'b1, line_sel = 1'b0, we_pulse = 1'b0, href_pulse = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_valid;
  logic [7:0] out_data;

  int n_tests = 0, n_fail = 0;
  int hist[$];
  int pos = 0;
  bit exp_v = 0;
  int exp_d = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dto_resampler dut_i (.clk(clk), .rst(rst), .cf(cf), .dto_on(dto_on),
    .line_sel(line_sel), .we_pulse(we_pulse), .href_pulse(href_pulse),
    .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

  function automatic int step_of(int c);
    return 256 + (c * 256 + 127) / 255;
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // behavioural reference: absolute position over the list of received samples
  task automatic model(bit v, int d, bit ls);
    bit pv = 0; int pd = exp_d;
    if (ls) begin
      hist.delete(); pos = 0;
      if (v) hist.push_back(d);
    end else if (v) begin
      hist.push_back(d);
      if (hist.size() - 1 == (pos / 256) + 1) begin
        int a = hist[pos / 256];
        int b = hist[hist.size() - 1];
        int t = ((b - a) * (pos % 256) + 128) >>> 8;
        int r = a + t;
        if (r < 0) r = 0;
        if (r > 255) r = 255;
        pv = 1; pd = r;
        pos += step_of(cf);
      end
    end
    if (!dto_on) begin exp_v = v; if (v) exp_d = d; end
    else begin exp_v = pv; exp_d = pd; end
  endtask

  task automatic cyc(bit v, int d, bit we, bit hr, string tag);
    in_valid = v; in_data = d[7:0]; we_pulse = we; href_pulse = hr;
    model(v, d, line_sel ? hr : we);
    @(negedge clk);
    n_tests++;
    if (out_valid !== exp_v || (exp_v && out_data !== exp_d[7:0])) begin
      n_fail++;
      $display("FAIL %s: valid=%0d data=%0d expected valid=%0d data=%0d",
               tag, out_valid, out_data, exp_v, exp_d);
    end
  endtask

  function automatic int pat(int kind, int i);
    case (kind)
      0: return (i * 3) % 256;
      1: return 255 - ((i * 5) % 256);
      2: return int'($urandom_range(0, 255));
      default: return (i % 2) ? 255 : 0;
    endcase
  endfunction

  // one line: optional merged start, optional valid gaps, optional pulse on the other pin
  task automatic line(int c, int len, int kind, bit merged, int gap, bit stray, string tag);
    cf = c[7:0];
    repeat (3) cyc(0, 0, 0, 0, tag);
    if (!merged) cyc(0, 0, !line_sel, line_sel, tag);
    for (int i = 0; i < len; i++) begin
      bit st = merged && (i == 0);
      bit other = stray && (i == len / 2);
      cyc(1, pat(kind, i), (st && !line_sel) || (other && line_sel),
          (st && line_sel) || (other && !line_sel), tag);
      if (gap > 0 && (i % gap) == gap - 1) cyc(0, 0, 0, 0, tag);
    end
    repeat (2) cyc(0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_tests++;
    if (out_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: out_valid=%0b expected 0 in reset", out_valid);
    end
    rst = 1'b0;
    hist.delete(); pos = 0; exp_v = 0; exp_d = 0;
    cyc(0, 0, 0, 0, "R1");
    line(0, 20, 0, 0, 0, 0, "R2");
    line(255, 24, 0, 0, 0, 0, "R5");
    line(100, 40, 0, 0, 0, 0, "R3");
    line(100, 40, 1, 0, 0, 0, "R4");
    line(37, 60, 2, 0, 0, 0, "R4");
    line(200, 50, 3, 0, 0, 0, "R4");
    line(170, 40, 2, 1, 0, 0, "R7");
    line(90, 40, 2, 0, 3, 0, "R9");
    line(128, 40, 0, 0, 0, 1, "R6");
    line_sel = 1'b1;
    line(60, 40, 1, 0, 0, 1, "R6");
    line(230, 30, 2, 1, 2, 0, "R7");
    dto_on = 1'b0;
    line(150, 30, 2, 0, 4, 0, "R8");
    dto_on = 1'b1;
    line(255, 30, 3, 0, 0, 0, "R2");
    summary();
    $finish;
  end
endmodule